// File: doc/BRIEF.md
# Bundle Issue Legality Checker

This block sits at the issue stage of a wide-instruction core and gives a verdict on each decoded bundle. The decoder provides a format code and, for each slot, a small operation-class code. From the format, the block knows the slot layout: how many slots the bundle has and which kind of operation each slot may carry. It checks every slot against that layout. It then works out which memory ports the bundle needs and compares that need with the ready lines of two load ports and one store port.

The verdict is registered and appears one cycle after the bundle is presented. It takes one of three forms. The bundle issues whole. The bundle is held, with a mask naming the blocking ports. The bundle is rejected as an illegal instruction. The compute units are treated as unlimited. The slot layout is the only limit on compute co-issue, and the memory ports are the only resource that can hold a bundle back. A held bundle never issues in part. The issue logic keeps presenting it until the needed ports are ready.

Top module: `bundle_issue_gate`

## Requirements
- R1: While rst_n is low, and on the first edge after it rises with no bundle, go_ok, go_hold, go_bad and hold_mask are all zero.
- R2: The verdict for a bundle presented with bndl_vld high at one rising edge appears on the outputs after that edge. When bndl_vld is low, all verdict outputs are zero after the edge.
- R3: Class codes are 0 empty, 1 load, 2 store, 3 multiply, 4 ALU and 5 load-store (one memory op that uses a load port and the store port). Codes 6 and 7 are illegal in every slot.
- R4: Slot kinds are LS (accepts empty, load, store and load-store), LD (accepts empty and load), MU (accepts empty and multiply) and AL (accepts empty and ALU). Class 0 is legal in every slot. Slot s carries bits [3s+2:3s] of bndl_cls.
- R5: The format layouts, by slot index from 0, are as follows. Formats 0 to 4 are LS,LD,MU,AL. Format 5 is LD,LD,MU,AL. Format 6 is LS,LD,MU,AL,AL. Format 7 is LD,AL,MU,AL,AL. Format 8 is LS,AL. Format 9 is LS,MU. Format 10 is LS,LD. Format 11 is a single slot that accepts any class from 1 to 5. A bundle whose slots all match its layout and whose needed ports are ready gives go_ok.
- R6: A slot beyond the format's slot count must carry class 0, or the bundle is illegal. Formats 12 to 15 are reserved and always illegal.
- R7: A multiply in an AL slot is legal only in formats 0, 1, 2, 3 and 6. In every other format it is illegal.
- R8: Loads take load ports in slot order: the first load or load-store gets load port 0 and the second gets load port 1. A store or load-store takes the store port. If any needed port is not ready, go_hold is raised and hold_mask shows the blocking ports: bit 0 is load port 0, bit 1 is load port 1 and bit 2 is the store port.
- R9: A port that the bundle does not need has no effect on the verdict, even when its ready line is low.
- R10: Illegality takes priority over holding. An illegal bundle gives go_bad with hold_mask zero, whatever the port readiness.
- R11: For each presented bundle, exactly one of go_ok, go_hold and go_bad is high. hold_mask is nonzero only together with go_hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bndl_vld | input | 1 | A decoded bundle is presented this cycle |
| bndl_fmt | input | 4 | Format code of the bundle |
| bndl_cls | input | 15 | Per-slot class codes, 3 bits per slot, slot 0 in the low bits |
| ld_port_rdy | input | 2 | Ready lines of load ports 0 and 1 |
| st_port_rdy | input | 1 | Ready line of the store port |
| go_ok | output | 1 | The bundle issues whole |
| go_hold | output | 1 | The bundle is held for a memory port |
| go_bad | output | 1 | The bundle is illegal |
| hold_mask | output | 3 | Blocking ports: load 0, load 1, store |

## Verification
The embedded checks assume that the class and format inputs are never X or Z while bndl_vld is high or while the combinational slot checks evaluate. They also assume that the ready lines are driven from reset onward. The bench drives every input to a known value before reset is released. It changes the inputs only at falling edges, so the registered verdict always reflects one stable bundle. The load and store totals can never exceed the port counts under the built-in layouts. The bench therefore reaches the port logic only through legal bundles and checks the holds through each port-ready pattern.

// File: rtl/bundle_issue_pkg.sv
package bundle_issue_pkg;

   localparam int CLS_W    = 3;
   localparam int FMT_W    = 4;
   localparam int BASE_SLT = 5;

   typedef enum logic [2:0] {
      OC_NONE = 3'd0,
      OC_LD   = 3'd1,
      OC_ST   = 3'd2,
      OC_MUL  = 3'd3,
      OC_ALU  = 3'd4,
      OC_LDST = 3'd5
   } op_cls_e;

   typedef enum logic [2:0] {
      SK_NONE = 3'd0,
      SK_LS   = 3'd1,
      SK_LD   = 3'd2,
      SK_MU   = 3'd3,
      SK_AL   = 3'd4,
      SK_ANY  = 3'd5
   } slot_kind_e;

   // slot kind for a format / slot index pair
   function automatic slot_kind_e layout_kind(input logic [FMT_W-1:0] fmt, input int s);
      slot_kind_e k;
      k = SK_NONE;
      unique case (fmt)
         4'd0, 4'd1, 4'd2, 4'd3, 4'd4: begin
            case (s)
               0: k = SK_LS;
               1: k = SK_LD;
               2: k = SK_MU;
               3: k = SK_AL;
               default: k = SK_NONE;
            endcase
         end
         4'd5: begin
            case (s)
               0, 1: k = SK_LD;
               2: k = SK_MU;
               3: k = SK_AL;
               default: k = SK_NONE;
            endcase
         end
         4'd6: begin
            case (s)
               0: k = SK_LS;
               1: k = SK_LD;
               2: k = SK_MU;
               3, 4: k = SK_AL;
               default: k = SK_NONE;
            endcase
         end
         4'd7: begin
            case (s)
               0: k = SK_LD;
               1, 3, 4: k = SK_AL;
               2: k = SK_MU;
               default: k = SK_NONE;
            endcase
         end
         4'd8:  k = (s == 0) ? SK_LS : ((s == 1) ? SK_AL : SK_NONE);
         4'd9:  k = (s == 0) ? SK_LS : ((s == 1) ? SK_MU : SK_NONE);
         4'd10: k = (s == 0) ? SK_LS : ((s == 1) ? SK_LD : SK_NONE);
         4'd11: k = (s == 0) ? SK_ANY : SK_NONE;
         default: k = SK_NONE;
      endcase
      return k;
   endfunction

   function automatic logic fmt_reserved(input logic [FMT_W-1:0] fmt);
      return (fmt > 4'd11);
   endfunction

endpackage

// File: rtl/bil_layout.sv
module bil_layout
   import bundle_issue_pkg::*;
#(
   parameter int                      NUM_SLOTS   = 5,
   parameter logic [2**FMT_W-1:0]     MULALU_MASK = 16'h004F
) (
   input  logic [FMT_W-1:0] fmt,
   output slot_kind_e       kind [NUM_SLOTS],
   output logic             mul_in_alu,
   output logic             reserved
);

   initial begin
      if (NUM_SLOTS < BASE_SLT)
         $error("bil_layout: NUM_SLOTS must cover the widest format");
   end

   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_slot
         if (s < BASE_SLT) begin : g_mapped
            always_comb kind[s] = layout_kind(fmt, s);
         end else begin : g_spare
            always_comb kind[s] = SK_NONE;
         end
      end
   endgenerate

   always_comb begin
      reserved   = fmt_reserved(fmt);
      mul_in_alu = MULALU_MASK[fmt] & ~reserved;
   end

   // R6 reserved formats expose no usable slot
   always_comb begin
      if (reserved) begin
         reserved_empty_chk: assert (kind[0] == SK_NONE && kind[1] == SK_NONE);
      end
   end

endmodule

// File: rtl/bil_slot_check.sv
module bil_slot_check
   import bundle_issue_pkg::*;
(
   input  slot_kind_e       kind,
   input  logic [CLS_W-1:0] cls,
   input  logic             mul_in_alu,
   output logic             ok,
   output logic             uses_ld,
   output logic             uses_st
);

   always_comb begin
      ok = 1'b0;
      if (cls == OC_NONE) begin
         ok = 1'b1;
      end else begin
         unique case (kind)
            SK_LS:   ok = (cls == OC_LD) || (cls == OC_ST) || (cls == OC_LDST);
            SK_LD:   ok = (cls == OC_LD);
            SK_MU:   ok = (cls == OC_MUL);
            SK_AL:   ok = (cls == OC_ALU) || ((cls == OC_MUL) && mul_in_alu);
            SK_ANY:  ok = (cls <= OC_LDST);
            default: ok = 1'b0;
         endcase
      end
      uses_ld = (cls == OC_LD) || (cls == OC_LDST);
      uses_st = (cls == OC_ST) || (cls == OC_LDST);
   end

   // R3 undefined class codes are never accepted
   always_comb begin
      if (cls > OC_LDST) begin
         bad_class_chk: assert (!ok);
      end
   end

   // R4 a load-only slot never passes a store
   always_comb begin
      if (kind == SK_LD && ok) begin
         ld_slot_nostore_chk: assert (!uses_st);
      end
   end

endmodule

// File: rtl/bil_port_arb.sv
module bil_port_arb #(
   parameter int N_LD  = 2,
   parameter int N_ST  = 1,
   parameter int CNT_W = 3
) (
   input  logic [CNT_W-1:0]     ld_total,
   input  logic [CNT_W-1:0]     st_total,
   input  logic [N_LD-1:0]      ld_rdy,
   input  logic [N_ST-1:0]      st_rdy,
   output logic                 over_budget,
   output logic [N_LD+N_ST-1:0] block
);

   logic [N_LD-1:0] need_ld;
   logic [N_ST-1:0] need_st;

   genvar p;
   generate
      for (p = 0; p < N_LD; p++) begin : g_ld
         always_comb need_ld[p] = (ld_total > CNT_W'(p));
         always_comb block[p]   = need_ld[p] & ~ld_rdy[p];
      end
      for (p = 0; p < N_ST; p++) begin : g_st
         always_comb need_st[p]    = (st_total > CNT_W'(p));
         always_comb block[N_LD+p] = need_st[p] & ~st_rdy[p];
      end
   endgenerate

   always_comb over_budget = (ld_total > CNT_W'(N_LD)) || (st_total > CNT_W'(N_ST));

   // R8 ports are claimed in order: a higher load port is never needed alone
   always_comb begin
      for (int i = 1; i < N_LD; i++) begin
         if (need_ld[i]) begin
            ld_order_chk: assert (need_ld[i-1]);
         end
      end
   end

endmodule

// File: rtl/bundle_issue_gate.sv
module bundle_issue_gate
   import bundle_issue_pkg::*;
#(
   parameter int                  NUM_SLOTS   = 5,
   parameter int                  N_LD        = 2,
   parameter int                  N_ST        = 1,
   parameter logic [2**FMT_W-1:0] MULALU_MASK = 16'h004F
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       bndl_vld,
   input  logic [FMT_W-1:0]           bndl_fmt,
   input  logic [NUM_SLOTS*CLS_W-1:0] bndl_cls,
   input  logic [N_LD-1:0]            ld_port_rdy,
   input  logic [N_ST-1:0]            st_port_rdy,
   output logic                       go_ok,
   output logic                       go_hold,
   output logic                       go_bad,
   output logic [N_LD+N_ST-1:0]       hold_mask
);

   localparam int CNT_W  = $clog2(NUM_SLOTS + 1);
   localparam int PORT_N = N_LD + N_ST;

   initial begin
      if (N_LD < 1 || N_ST < 1)
         $error("bundle_issue_gate: at least one load and one store port required");
      if (NUM_SLOTS < BASE_SLT)
         $error("bundle_issue_gate: NUM_SLOTS too small");
   end

   slot_kind_e            kind [NUM_SLOTS];
   logic                  mul_in_alu;
   logic                  reserved;
   logic [NUM_SLOTS-1:0]  slot_ok;
   logic [NUM_SLOTS-1:0]  slot_ld;
   logic [NUM_SLOTS-1:0]  slot_st;
   logic [CNT_W-1:0]      ld_total;
   logic [CNT_W-1:0]      st_total;
   logic                  over_budget;
   logic [PORT_N-1:0]     block;
   logic                  illegal;

   bil_layout #(
      .NUM_SLOTS   (NUM_SLOTS),
      .MULALU_MASK (MULALU_MASK)
   ) u_layout (
      .fmt        (bndl_fmt),
      .kind       (kind),
      .mul_in_alu (mul_in_alu),
      .reserved   (reserved)
   );

   genvar s;
   generate
      for (s = 0; s < NUM_SLOTS; s++) begin : g_chk
         bil_slot_check u_slot (
            .kind       (kind[s]),
            .cls        (bndl_cls[s*CLS_W +: CLS_W]),
            .mul_in_alu (mul_in_alu),
            .ok         (slot_ok[s]),
            .uses_ld    (slot_ld[s]),
            .uses_st    (slot_st[s])
         );
      end
   endgenerate

   always_comb begin
      ld_total = '0;
      st_total = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         ld_total = ld_total + CNT_W'(slot_ld[i]);
         st_total = st_total + CNT_W'(slot_st[i]);
      end
   end

   bil_port_arb #(
      .N_LD  (N_LD),
      .N_ST  (N_ST),
      .CNT_W (CNT_W)
   ) u_arb (
      .ld_total    (ld_total),
      .st_total    (st_total),
      .ld_rdy      (ld_port_rdy),
      .st_rdy      (st_port_rdy),
      .over_budget (over_budget),
      .block       (block)
   );

   always_comb illegal = reserved | ~(&slot_ok) | over_budget;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         go_ok     <= 1'b0;
         go_hold   <= 1'b0;
         go_bad    <= 1'b0;
         hold_mask <= '0;
      end else if (!bndl_vld) begin
         go_ok     <= 1'b0;
         go_hold   <= 1'b0;
         go_bad    <= 1'b0;
         hold_mask <= '0;
      end else if (illegal) begin
         go_ok     <= 1'b0;
         go_hold   <= 1'b0;
         go_bad    <= 1'b1;
         hold_mask <= '0;
      end else if (|block) begin
         go_ok     <= 1'b0;
         go_hold   <= 1'b1;
         go_bad    <= 1'b0;
         hold_mask <= block;
      end else begin
         go_ok     <= 1'b1;
         go_hold   <= 1'b0;
         go_bad    <= 1'b0;
         hold_mask <= '0;
      end
   end

   // R2 no bundle presented, nothing reported
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bndl_vld |=> !(go_ok || go_hold || go_bad));

   // R11 a presented bundle gets exactly one verdict
   one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bndl_vld |=> ($countones({go_ok, go_hold, go_bad}) == 1));

   // R11 the blocking mask only accompanies a hold
   mask_with_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hold_mask != '0) |-> go_hold);

   // R9 with every port ready no bundle is held
   all_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bndl_vld && (&ld_port_rdy) && (&st_port_rdy)) |=> !go_hold);

   // R8 a hold never follows a bundle with no memory op
   hold_needs_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bndl_vld && slot_ld == '0 && slot_st == '0) |=> !go_hold);

endmodule

// File: tb/bundle_issue_gate_tb.sv
module bundle_issue_gate_tb;

   localparam int E = 0, L = 1, S = 2, M = 3, A = 4, X = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bndl_vld = 1'b0;
   logic [3:0]  bndl_fmt = '0;
   logic [14:0] bndl_cls = '0;
   logic [1:0]  ld_port_rdy = 2'b11;
   logic [0:0]  st_port_rdy = 1'b1;
   logic        go_ok, go_hold, go_bad;
   logic [2:0]  hold_mask;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   bundle_issue_gate u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bndl_vld    (bndl_vld),
      .bndl_fmt    (bndl_fmt),
      .bndl_cls    (bndl_cls),
      .ld_port_rdy (ld_port_rdy),
      .st_port_rdy (st_port_rdy),
      .go_ok       (go_ok),
      .go_hold     (go_hold),
      .go_bad      (go_bad),
      .hold_mask   (hold_mask)
   );

   function automatic logic [14:0] pk(int c0, int c1, int c2, int c3, int c4);
      return {3'(c4), 3'(c3), 3'(c2), 3'(c1), 3'(c0)};
   endfunction

   task automatic expect_v(string req, bit eo, bit eh, bit eb, logic [2:0] em);
      checks++;
      if ({go_ok, go_hold, go_bad, hold_mask} !== {eo, eh, eb, em}) begin
         errors++;
         $display("FAIL %s: ok/hold/bad/mask actual %b%b%b %b expected %b%b%b %b",
                  req, go_ok, go_hold, go_bad, hold_mask, eo, eh, eb, em);
      end
   endtask

   task automatic present(int fmt, logic [14:0] cls, logic [1:0] ldr, logic str);
      @(negedge clk);
      bndl_vld    = 1'b1;
      bndl_fmt    = 4'(fmt);
      bndl_cls    = cls;
      ld_port_rdy = ldr;
      st_port_rdy = str;
      @(posedge clk);
      #1;
   endtask

   task automatic t_reset();
      @(posedge clk); #1;
      expect_v("R1 in reset", 0, 0, 0, 3'b000);
      @(negedge clk);
      rst_n    = 1'b1;
      bndl_vld = 1'b0;
      @(posedge clk); #1;
      expect_v("R1 after release", 0, 0, 0, 3'b000);
   endtask

   task automatic t_idle();
      @(negedge clk);
      bndl_vld = 1'b0; bndl_fmt = 4'd13; bndl_cls = '1; ld_port_rdy = '0; st_port_rdy = '0;
      @(posedge clk); #1;
      expect_v("R2 idle ignores inputs", 0, 0, 0, 3'b000);
   endtask

   task automatic t_layouts();
      present(0, pk(X, L, M, A, E), 2'b11, 1'b1);  expect_v("R5 fmt0 full", 1, 0, 0, 0);
      present(5, pk(L, L, M, A, E), 2'b11, 1'b1);  expect_v("R5 fmt5 two loads", 1, 0, 0, 0);
      present(6, pk(S, L, M, A, A), 2'b11, 1'b1);  expect_v("R5 fmt6 five ops", 1, 0, 0, 0);
      present(7, pk(L, A, M, A, A), 2'b11, 1'b1);  expect_v("R5 fmt7 five ops", 1, 0, 0, 0);
      present(9, pk(S, M, E, E, E), 2'b11, 1'b1);  expect_v("R5 fmt9 narrow", 1, 0, 0, 0);
      present(11, pk(X, E, E, E, E), 2'b11, 1'b1); expect_v("R5 fmt11 single", 1, 0, 0, 0);
      present(2, pk(E, E, E, E, E), 2'b00, 1'b0);  expect_v("R4 all empty", 1, 0, 0, 0);
   endtask

   task automatic t_classes();
      present(0, pk(E, E, E, 6, E), 2'b11, 1'b1);  expect_v("R3 code 6", 0, 0, 1, 0);
      present(11, pk(7, E, E, E, E), 2'b11, 1'b1); expect_v("R3 code 7 any slot", 0, 0, 1, 0);
      present(0, pk(E, S, E, E, E), 2'b11, 1'b1);  expect_v("R4 store in LD slot", 0, 0, 1, 0);
      present(1, pk(A, E, E, E, E), 2'b11, 1'b1);  expect_v("R4 ALU in LS slot", 0, 0, 1, 0);
      present(10, pk(E, X, E, E, E), 2'b11, 1'b1); expect_v("R4 load-store in LD slot", 0, 0, 1, 0);
      present(3, pk(E, E, A, E, E), 2'b11, 1'b1);  expect_v("R4 ALU in MU slot", 0, 0, 1, 0);
   endtask

   task automatic t_count();
      present(8, pk(E, A, A, E, E), 2'b11, 1'b1);  expect_v("R6 op past slot count", 0, 0, 1, 0);
      present(0, pk(E, E, E, E, A), 2'b11, 1'b1);  expect_v("R6 fifth slot in fmt0", 0, 0, 1, 0);
      present(13, pk(E, E, E, E, E), 2'b11, 1'b1); expect_v("R6 reserved fmt", 0, 0, 1, 0);
   endtask

   task automatic t_mul_alu();
      present(0, pk(E, E, M, M, E), 2'b11, 1'b1);  expect_v("R7 fmt0 mul in AL", 1, 0, 0, 0);
      present(6, pk(E, E, E, E, M), 2'b11, 1'b1);  expect_v("R7 fmt6 mul in AL", 1, 0, 0, 0);
      present(4, pk(E, E, E, M, E), 2'b11, 1'b1);  expect_v("R7 fmt4 mul in AL", 0, 0, 1, 0);
      present(7, pk(E, M, E, E, E), 2'b11, 1'b1);  expect_v("R7 fmt7 mul in AL", 0, 0, 1, 0);
      present(8, pk(E, M, E, E, E), 2'b11, 1'b1);  expect_v("R7 fmt8 mul in AL", 0, 0, 1, 0);
   endtask

   task automatic t_ports();
      present(5, pk(L, L, E, E, E), 2'b01, 1'b1);  expect_v("R8 second load blocked", 0, 1, 0, 3'b010);
      present(0, pk(S, E, E, A, E), 2'b11, 1'b0);  expect_v("R8 store blocked", 0, 1, 0, 3'b100);
      present(0, pk(X, L, E, E, E), 2'b00, 1'b0);  expect_v("R8 all blocked", 0, 1, 0, 3'b111);
      present(10, pk(E, L, E, E, E), 2'b10, 1'b1); expect_v("R8 lone load uses port0", 0, 1, 0, 3'b001);
      present(0, pk(X, E, E, E, E), 2'b11, 1'b1);  expect_v("R8 load-store ready", 1, 0, 0, 0);
   endtask

   task automatic t_unused();
      present(0, pk(E, L, M, A, E), 2'b01, 1'b0);  expect_v("R9 unneeded ports low", 1, 0, 0, 0);
      present(9, pk(E, M, E, E, E), 2'b00, 1'b0);  expect_v("R9 no mem op", 1, 0, 0, 0);
      present(11, pk(S, E, E, E, E), 2'b00, 1'b1); expect_v("R9 store only", 1, 0, 0, 0);
   endtask

   task automatic t_priority();
      present(0, pk(X, L, A, E, E), 2'b00, 1'b0);  expect_v("R10 illegal over hold", 0, 0, 1, 0);
      present(14, pk(L, E, E, E, E), 2'b00, 1'b0); expect_v("R10 reserved over hold", 0, 0, 1, 0);
      @(negedge clk);
      bndl_vld = 1'b0;
      @(posedge clk); #1;
      expect_v("R11 verdict clears", 0, 0, 0, 0);
   endtask

   initial begin
      #150000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_idle();
      t_layouts();
      t_classes();
      t_count();
      t_mul_alu();
      t_ports();
      t_unused();
      t_priority();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule